// File: doc/BRIEF.md
# High-Address Dynamic Port

This block is an 8-bit quasi-bidirectional port. Its pins are shared over time between two sources. One is a held output latch that the internal bus writes. The other is the upper byte of an external-memory address.

A select input picks the source in each cycle. The pins follow that choice combinationally, so the select may toggle every cycle. Address output takes its own path and never writes the latch. Whatever was latched therefore shows again on the pins as soon as the select returns to I/O mode.

Each pin is modelled as a pull-down enable with an implied weak pull-up. A bit can be read as an input only while its driven value is 1; a 0 clamps the pin low. Reads come in two kinds. A read-latch request returns the latch, which is what read-modify-write sequences need. A read-pin request returns the sampled pin levels. Both results are registered and appear one cycle after the request. Reads are single-cycle requests with no back-pressure: a result is presented for exactly one cycle, flagged by `rd_valid`, and is not held.

Top module: `hiaddr_port`

## Requirements
- R1: During and right after reset, the latch holds all ones. `pull_dn` is all zeros, `rd_valid` is 0 and `rd_data` is 0.
- R2: While `addr_sel` is 0, `pull_dn[i]` equals the inverse of latch bit i, in the same cycle.
- R3: While `addr_sel` is 1, `pull_dn[i]` equals the inverse of `addr_hi[i]` in the same cycle, including when `addr_sel` changes every cycle.
- R4: When `wr_en` is 1 at a rising clock edge, the latch takes `wr_data`. In I/O mode the new value drives the pins from that edge on.
- R5: A write made while `addr_sel` is 1 updates the latch, but the pins keep following `addr_hi` until `addr_sel` returns to 0. From then on they show the new latch value.
- R6: Address mode leaves the latch unchanged. After `addr_sel` returns to 0, the value latched before address mode reappears on the pins.
- R7: A `rd_latch_req` at an edge gives `rd_valid`=1 and `rd_data` equal to the latch value before that edge. The result appears one cycle later. A write in the same cycle is therefore not seen.
- R8: A `rd_pin_req` alone at an edge gives `rd_valid`=1 and `rd_data` equal to `pin_in` sampled at that edge.
- R9: When both requests are present, the latch read wins.
- R10: An edge with no read request gives `rd_valid`=0 and `rd_data`=0 in the following cycle.
- R11: The pin level is the external level ANDed with the inverse of `pull_dn`. A latch bit of 0 reads back as 0 on a pin read whatever the external level, and a latch bit of 1 returns the external level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | 8 | Latch write value |
| rd_pin_req | input | 1 | Request a pin-level read |
| rd_latch_req | input | 1 | Request a latch read (read-modify-write) |
| addr_sel | input | 1 | 1 selects the address byte for the pins, 0 selects the latch |
| addr_hi | input | 8 | Upper address byte |
| pin_in | input | 8 | Sampled pin levels |
| pull_dn | output | 8 | Per-bit pull-down enable; 0 leaves the weak pull-up in charge |
| rd_valid | output | 1 | Read result present this cycle |
| rd_data | output | 8 | Read result |

## Verification
The bench writes to the latch while address mode is active. A design that routes the address through the latch would lose the earlier value, or would show the new value too early. The bench also toggles the select on consecutive cycles, which exposes a registered multiplexer by its one-cycle lag. A read-latch request arrives in the same cycle as a write; a design that bypasses the write would return the new data. Pin reads are made with some latch bits at 0, so a design that fails to clamp those pins would read back the external high.

// File: rtl/hiaddr_port_pkg.sv
package hiaddr_port_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_PIN   = 2'd1,
    SRC_LATCH = 2'd2
  } rd_src_e;
endpackage

// File: rtl/hap_latch.sv
module hap_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '1;
    else if (wr_en) q <= wr_data;
  end

  // R6: nothing but a write changes the latch, address mode included
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
  // R4
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wr_data));
endmodule

// File: rtl/hap_drive_mux.sv
module hap_drive_mux #(
  parameter int W = 8
) (
  input  logic         sel,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] addr,
  output logic [W-1:0] pull_dn
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic drv;
    assign drv        = sel ? addr[i] : latch_q[i];
    assign pull_dn[i] = ~drv;
  end
endmodule

// File: rtl/hap_read_sel.sv
module hap_read_sel
  import hiaddr_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_pin,
  input  logic         rd_latch,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] latch_q,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  rd_src_e src;

  always_comb begin
    if (rd_latch)    src = SRC_LATCH;
    else if (rd_pin) src = SRC_PIN;
    else             src = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= (src != SRC_NONE);
      unique case (src)
        SRC_LATCH: rd_data <= latch_q;
        SRC_PIN:   rd_data <= pin_in;
        default:   rd_data <= '0;
      endcase
    end
  end

  // R7 and R9: the latch request takes priority
  p_latch_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch |=> rd_valid && rd_data == $past(latch_q));
  p_pin_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pin && !rd_latch) |=> rd_valid && rd_data == $past(pin_in));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_pin && !rd_latch) |=> !rd_valid && rd_data == '0);
endmodule

// File: rtl/hiaddr_port.sv
module hiaddr_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_pin_req,
  input  logic         rd_latch_req,
  input  logic         addr_sel,
  input  logic [W-1:0] addr_hi,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pull_dn,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] latch_q;

  hap_latch #(.W(W)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .q(latch_q)
  );

  hap_drive_mux #(.W(W)) u_mux (
    .sel(addr_sel), .latch_q(latch_q), .addr(addr_hi), .pull_dn(pull_dn)
  );

  hap_read_sel #(.W(W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_pin(rd_pin_req), .rd_latch(rd_latch_req),
    .pin_in(pin_in), .latch_q(latch_q), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  p_addr_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_sel |-> pull_dn == ~addr_hi);
  p_io_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_sel |-> pull_dn == ~latch_q);
  // R5: a write in address mode must not reach the pins
  p_addr_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_sel && wr_en) |=> (addr_sel -> pull_dn == ~addr_hi));
endmodule

// File: tb/hiaddr_port_tb.sv
module hiaddr_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_pin_req = 1'b0;
  logic       rd_latch_req = 1'b0;
  logic       addr_sel = 1'b0;
  logic [7:0] addr_hi = '0;
  logic [7:0] ext_lvl = 8'hAA;
  logic [7:0] pin_in;
  logic [7:0] pull_dn;
  logic       rd_valid;
  logic [7:0] rd_data;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  // R11: wired pin model, weak pull-up against the pull-down
  assign pin_in = ext_lvl & ~pull_dn;

  hiaddr_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_pin_req(rd_pin_req), .rd_latch_req(rd_latch_req),
    .addr_sel(addr_sel), .addr_hi(addr_hi), .pin_in(pin_in),
    .pull_dn(pull_dn), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {wr_en, wr_data, addr_sel, addr_hi, expected pull_dn before the edge}
  localparam int NV = 11;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b0, 8'h00, 8'h00},  // R1 latch at reset value
    {1'b1, 8'hA5, 1'b0, 8'h00, 8'h00},  // R4 write, not yet visible
    {1'b0, 8'h00, 1'b0, 8'h00, 8'h5A},  // R4 visible after edge
    {1'b0, 8'h00, 1'b1, 8'h3C, 8'hC3},  // R3 address drives
    {1'b1, 8'h0F, 1'b1, 8'hF0, 8'h0F},  // R5 write in address mode
    {1'b0, 8'h00, 1'b1, 8'h81, 8'h7E},  // R5 pins still address
    {1'b0, 8'h00, 1'b0, 8'h00, 8'hF0},  // R5 new latch on exit
    {1'b0, 8'h00, 1'b1, 8'h00, 8'hFF},  // R3 toggle
    {1'b0, 8'h00, 1'b0, 8'h00, 8'hF0},  // R6 latch reappears
    {1'b1, 8'hFF, 1'b0, 8'h00, 8'hF0},  // R2
    {1'b0, 8'h00, 1'b0, 8'h00, 8'h00}   // R2 all ones released
  };

  initial begin : watchdog
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 pull_dn", {1'b0, pull_dn}, 9'h000);
    chk("R1 rd_valid", {8'h00, rd_valid}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_data", {1'b0, rd_data}, 9'h000);

    for (int i = 0; i < NV; i++) begin
      {wr_en, wr_data, addr_sel, addr_hi} = VEC[i][25:8];
      #1;
      chk($sformatf("R2/R3 vec%0d", i), {1'b0, pull_dn}, {1'b0, VEC[i][7:0]});
      @(negedge clk);
    end
    wr_en = 1'b0; addr_sel = 1'b0;

    // latch = FF; write 0F
    wr_en = 1'b1; wr_data = 8'h0F;
    @(negedge clk);
    wr_en = 1'b0;
    // R11 / R8: pin read with low latch bits clamped
    rd_pin_req = 1'b1;
    @(negedge clk);
    rd_pin_req = 1'b0;
    chk("R8 valid", {8'h00, rd_valid}, 9'h001);
    chk("R11 pin read", {1'b0, rd_data}, 9'h00A);
    // R7 latch read
    rd_latch_req = 1'b1;
    @(negedge clk);
    chk("R7 latch read", {rd_valid, rd_data}, 9'h10F);
    // R9 both requests
    rd_pin_req = 1'b1;
    @(negedge clk);
    rd_pin_req = 1'b0;
    chk("R9 priority", {rd_valid, rd_data}, 9'h10F);
    // R7 write and latch read in same cycle: old value returned
    wr_en = 1'b1; wr_data = 8'h33;
    @(negedge clk);
    wr_en = 1'b0; rd_latch_req = 1'b0;
    chk("R7 same-cycle write", {rd_valid, rd_data}, 9'h10F);
    // R10 idle
    @(negedge clk);
    chk("R10 idle", {rd_valid, rd_data}, 9'h000);
    // R11 / R8 in address mode, all ones driven
    addr_sel = 1'b1; addr_hi = 8'hFF; rd_pin_req = 1'b1;
    @(negedge clk);
    rd_pin_req = 1'b0;
    chk("R11 addr pin read", {rd_valid, rd_data}, 9'h1AA);
    // R6 latch read during address mode shows untouched latch
    rd_latch_req = 1'b1;
    @(negedge clk);
    rd_latch_req = 1'b0; addr_sel = 1'b0;
    chk("R6 latch kept", {rd_valid, rd_data}, 9'h133);
    #1;
    chk("R6 pins back", {1'b0, pull_dn}, 9'h0CC);
    // R3 per-cycle toggling
    for (int k = 0; k < 4; k++) begin
      addr_sel = k[0]; addr_hi = 8'h5A;
      #1;
      chk("R3 toggle", {1'b0, pull_dn}, k[0] ? 9'h0A5 : 9'h0CC);
      @(negedge clk);
    end
    // R1 reset again restores all ones
    addr_sel = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 re-reset", {rd_valid, pull_dn}, 9'h000);
    rst_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule